// File: doc/BRIEF.md
# Serial Gamepad Polling Host

This block is the console side of a serial game controller port. A free-running timer opens a poll frame at a fixed rate. In each frame the host releases the latch line for a short pulse so that the pad can capture its buttons. It then toggles the clock line sixteen times and reads one bit of serial data at the start of every low phase of the clock. Both control lines are open-drain. The block never drives them high. Each output is a pull-low enable, and an external pull-up supplies the high level.

The pad reports active-low data. The host inverts each sample, so in the button word a 1 means pressed. When the sixteenth sample reads low, a pointing device (mouse) is attached. If mouse support is enabled, the host then waits a programmable gap and clocks sixteen more bits, which carry the motion report, without a new latch pulse. At the end of the frame the button word, the motion word, a mouse flag and a no-device flag are updated together with a single-cycle valid strobe. All durations are parameters counted in system clock cycles.

Top module: `gamepad_poll_host`

## Requirements
- R1: A frame begins every FRAME_CYC cycles. The first latch release comes FRAME_CYC cycles after reset, and a new frame cannot start until the previous one has finished.
- R2: The latch pull-low enable is 0 for exactly LATCH_CYC cycles at the start of each frame and 1 at all other times.
- R3: The clock pull-low enable is 0 when idle. It first goes to 1 exactly GAP_CYC cycles after the latch is pulled low again. It then forms 16 low phases of HALF_CYC cycles, each followed by HALF_CYC released cycles.
- R4: The data input is sampled in the first cycle of each low phase. Sample k (k = 0..15) is inverted and placed in button bit k. Bit order from 0: B, Y, Select, Start, Up, Down, Left, Right, A, X, L, R, and bits 12 to 15 are unassigned.
- R5: `valid_o` is high for exactly one cycle, and all result outputs change only in that cycle. For a gamepad frame, `valid_o` rises LATCH_CYC+GAP_CYC+32·HALF_CYC cycles after the frame begins. Both control lines are idle during the strobe.
- R6: If MOUSE_EN is set and sample 15 is low, a second burst of 16 low phases with the same timing starts MGAP_CYC cycles after the end of the first burst, with no latch pulse. Its inverted samples fill `motion_o` bits 0..15 in order, and the valid strobe moves to the end of the second burst.
- R7: `mouse_o` is 1 exactly when sample 15 of the frame was low. For a frame without a mouse, `motion_o` is 0.
- R8: `nodev_o` is 1 exactly when all 16 samples of the first burst were high (empty port). In that case `buttons_o` is 0 and `mouse_o` is 0.
- R9: During and straight after reset the latch is pulled low, the clock is released, and `valid_o`, `buttons_o`, `motion_o`, `mouse_o` and `nodev_o` are 0.
- R10: The clock is never pulled low while the latch is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_data_i | input | 1 | Serial data from the pad, active low, pulled high when no pad is present |
| latch_pull_o | output | 1 | 1 pulls the latch line low, 0 releases it (line high) |
| clk_pull_o | output | 1 | 1 pulls the pad clock line low, 0 releases it (line high) |
| buttons_o | output | NBITS | Inverted first-burst samples, 1 = pressed |
| motion_o | output | NBITS | Inverted second-burst samples, 0 without a mouse |
| valid_o | output | 1 | One-cycle strobe when the results update |
| mouse_o | output | 1 | Sample 15 was low in the last frame |
| nodev_o | output | 1 | All first-burst samples were high in the last frame |

## Verification
The checker watches several properties on every cycle:
- Each latch release lasts exactly LATCH_CYC cycles, and each clock low phase lasts exactly HALF_CYC cycles.
- The clock is never pulled while the latch is released.
- The valid strobe lasts one cycle and arrives with both lines idle.
- The results stay frozen between strobes.
- The mouse and no-device flags agree with the button word.

Other behaviour only the bench scenarios can show. These are the frame period, the gap before the first clock, the gap before the second burst, and the cycle of the strobe. They also include the mapping of each serial position to its output bit, and the choice between a one-burst and a two-burst frame. For these checks the bench plays an empty port, several gamepad patterns and two mouse reports against a behavioural timing schedule.

// File: rtl/gpoll_pkg.sv
package gpoll_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LATCH,
        PH_GAP,
        PH_LOW,
        PH_HIGH,
        PH_MGAP
    } phase_e;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/gpoll_frame_timer.sv
module gpoll_frame_timer #(
    parameter int FRAME_CYC = 833_500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int TW = $clog2(FRAME_CYC);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        tick_o = (tmr_q.cnt == TW'(FRAME_CYC - 1));
        if (tick_o) tmr_d.cnt = '0;
        else        tmr_d.cnt = tmr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/gpoll_seq.sv
module gpoll_seq
    import gpoll_pkg::*;
#(
    parameter int LATCH_CYC = 600,
    parameter int GAP_CYC   = 300,
    parameter int HALF_CYC  = 300,
    parameter int MGAP_CYC  = 125_000,
    parameter int NBITS     = 16,
    parameter bit MOUSE_EN  = 1'b1,
    localparam int IW       = $clog2(2 * NBITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mouse_seen_i,
    output logic          latch_pull_o,
    output logic          clk_pull_o,
    output logic          begin_o,
    output logic          sample_o,
    output logic [IW-1:0] bit_o,
    output logic          done_o
);
    localparam int MAXC = max_of4(LATCH_CYC, GAP_CYC, HALF_CYC, MGAP_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
    } seq_s;

    seq_s seq_d, seq_q;
    logic mouse_go;

    generate
        if (MOUSE_EN) begin : g_mouse
            assign mouse_go = mouse_seen_i;
        end else begin : g_pad_only
            assign mouse_go = 1'b0;
        end
    endgenerate

    always_comb begin
        seq_d   = seq_q;
        begin_o = 1'b0;
        done_o  = 1'b0;
        case (seq_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.ph  = PH_LATCH;
                    seq_d.cnt = '0;
                    begin_o   = 1'b1;
                end
            end
            PH_LATCH: begin
                if (seq_q.cnt == CW'(LATCH_CYC - 1)) begin
                    seq_d.ph  = PH_GAP;
                    seq_d.cnt = '0;
                    seq_d.idx = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PH_GAP: begin
                if (seq_q.cnt == CW'(GAP_CYC - 1)) begin
                    seq_d.ph  = PH_LOW;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PH_LOW: begin
                if (seq_q.cnt == CW'(HALF_CYC - 1)) begin
                    seq_d.ph  = PH_HIGH;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PH_HIGH: begin
                if (seq_q.cnt == CW'(HALF_CYC - 1)) begin
                    seq_d.cnt = '0;
                    if (seq_q.idx == IW'(NBITS - 1)) begin
                        if (mouse_go) begin
                            seq_d.ph  = PH_MGAP;
                            seq_d.idx = IW'(NBITS);
                        end else begin
                            seq_d.ph = PH_IDLE;
                            done_o   = 1'b1;
                        end
                    end else if (seq_q.idx == IW'(2 * NBITS - 1)) begin
                        seq_d.ph = PH_IDLE;
                        done_o   = 1'b1;
                    end else begin
                        seq_d.ph  = PH_LOW;
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PH_MGAP: begin
                if (seq_q.cnt == CW'(MGAP_CYC - 1)) begin
                    seq_d.ph  = PH_LOW;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{ph: PH_IDLE, cnt: '0, idx: '0};
        else        seq_q <= seq_d;
    end

    assign latch_pull_o = (seq_q.ph != PH_LATCH);
    assign clk_pull_o   = (seq_q.ph == PH_LOW);
    assign sample_o     = (seq_q.ph == PH_LOW) && (seq_q.cnt == '0);
    assign bit_o        = seq_q.idx;
endmodule

// File: rtl/gpoll_capture.sv
module gpoll_capture #(
    parameter int NBITS    = 16,
    parameter bit MOUSE_EN = 1'b1,
    localparam int IW      = $clog2(2 * NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             begin_i,
    input  logic             sample_i,
    input  logic [IW-1:0]    bit_i,
    input  logic             sdata_i,
    input  logic             done_i,
    output logic             mouse_seen_o,
    output logic [NBITS-1:0] buttons_o,
    output logic [NBITS-1:0] motion_o,
    output logic             valid_o,
    output logic             mouse_o,
    output logic             nodev_o
);
    typedef struct packed {
        logic [2*NBITS-1:0] word;
        logic [NBITS-1:0]   buttons;
        logic [NBITS-1:0]   motion;
        logic               valid;
        logic               mouse;
        logic               nodev;
    } cap_s;

    cap_s cap_d, cap_q;
    logic had_mouse;

    assign had_mouse = MOUSE_EN && cap_q.word[NBITS-1];

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = 1'b0;
        if (begin_i) cap_d.word = '0;
        if (sample_i) cap_d.word[bit_i] = ~sdata_i;
        if (done_i) begin
            cap_d.valid   = 1'b1;
            cap_d.buttons = cap_q.word[NBITS-1:0];
            cap_d.mouse   = cap_q.word[NBITS-1];
            cap_d.nodev   = ~|cap_q.word[NBITS-1:0];
            cap_d.motion  = had_mouse ? cap_q.word[2*NBITS-1:NBITS] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign mouse_seen_o = cap_q.word[NBITS-1];
    assign buttons_o    = cap_q.buttons;
    assign motion_o     = cap_q.motion;
    assign valid_o      = cap_q.valid;
    assign mouse_o      = cap_q.mouse;
    assign nodev_o      = cap_q.nodev;
endmodule

// File: rtl/gamepad_poll_host.sv
module gamepad_poll_host #(
    parameter int FRAME_CYC = 833_500,
    parameter int LATCH_CYC = 600,
    parameter int GAP_CYC   = 300,
    parameter int HALF_CYC  = 300,
    parameter int MGAP_CYC  = 125_000,
    parameter int NBITS     = 16,
    parameter bit MOUSE_EN  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pad_data_i,
    output logic             latch_pull_o,
    output logic             clk_pull_o,
    output logic [NBITS-1:0] buttons_o,
    output logic [NBITS-1:0] motion_o,
    output logic             valid_o,
    output logic             mouse_o,
    output logic             nodev_o
);
    localparam int IW = $clog2(2 * NBITS);

    logic          tick;
    logic          mouse_seen;
    logic          frame_begin;
    logic          sample_now;
    logic [IW-1:0] bit_idx;
    logic          frame_done;

    gpoll_frame_timer #(.FRAME_CYC(FRAME_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    gpoll_seq #(
        .LATCH_CYC (LATCH_CYC),
        .GAP_CYC   (GAP_CYC),
        .HALF_CYC  (HALF_CYC),
        .MGAP_CYC  (MGAP_CYC),
        .NBITS     (NBITS),
        .MOUSE_EN  (MOUSE_EN)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (tick),
        .mouse_seen_i (mouse_seen),
        .latch_pull_o (latch_pull_o),
        .clk_pull_o   (clk_pull_o),
        .begin_o      (frame_begin),
        .sample_o     (sample_now),
        .bit_o        (bit_idx),
        .done_o       (frame_done)
    );

    gpoll_capture #(
        .NBITS    (NBITS),
        .MOUSE_EN (MOUSE_EN)
    ) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .begin_i      (frame_begin),
        .sample_i     (sample_now),
        .bit_i        (bit_idx),
        .sdata_i      (pad_data_i),
        .done_i       (frame_done),
        .mouse_seen_o (mouse_seen),
        .buttons_o    (buttons_o),
        .motion_o     (motion_o),
        .valid_o      (valid_o),
        .mouse_o      (mouse_o),
        .nodev_o      (nodev_o)
    );
endmodule

// File: rtl/gpoll_host_chk.sv
module gpoll_host_chk #(
    parameter int LATCH_CYC = 600,
    parameter int HALF_CYC  = 300,
    parameter int NBITS     = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             latch_pull_o,
    input logic             clk_pull_o,
    input logic [NBITS-1:0] buttons_o,
    input logic [NBITS-1:0] motion_o,
    input logic             valid_o,
    input logic             mouse_o,
    input logic             nodev_o
);
    int rel_run;
    int low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_run <= 0;
            low_run <= 0;
        end else begin
            rel_run <= latch_pull_o ? 0 : rel_run + 1;
            low_run <= clk_pull_o ? low_run + 1 : 0;
        end
    end

    // R2
    latch_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_pull_o) |-> rel_run == LATCH_CYC);

    // R3
    clk_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_pull_o) |-> low_run == HALF_CYC);

    // R10
    clock_idle_in_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_pull_o |-> !clk_pull_o);

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R5
    valid_lines_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (latch_pull_o && !clk_pull_o));

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(buttons_o) && $stable(motion_o) && $stable(mouse_o) && $stable(nodev_o)));

    // R7
    mouse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mouse_o |-> buttons_o[NBITS-1]);

    // R7
    motion_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mouse_o |-> motion_o == '0);

    // R8
    nodev_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nodev_o |-> (buttons_o == '0 && !mouse_o));
endmodule

bind gamepad_poll_host gpoll_host_chk #(
    .LATCH_CYC (LATCH_CYC),
    .HALF_CYC  (HALF_CYC),
    .NBITS     (NBITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .latch_pull_o (latch_pull_o),
    .clk_pull_o   (clk_pull_o),
    .buttons_o    (buttons_o),
    .motion_o     (motion_o),
    .valid_o      (valid_o),
    .mouse_o      (mouse_o),
    .nodev_o      (nodev_o)
);

// File: tb/test_gamepad_poll_host.sv
`timescale 1ns/1ps
module test_gamepad_poll_host;
    localparam int F = 400;
    localparam int L = 6;
    localparam int G = 3;
    localparam int H = 3;
    localparam int M = 20;
    localparam int T0 = L + G + 32 * H;
    localparam int B2 = T0 + M;
    localparam int T1 = B2 + 32 * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pad_data = 1'b1;
    logic        latch_pull, clk_pull, valid, mouse, nodev;
    logic [15:0] buttons, motion;

    always #2.5 clk = ~clk;

    gamepad_poll_host #(
        .FRAME_CYC (F), .LATCH_CYC (L), .GAP_CYC (G), .HALF_CYC (H),
        .MGAP_CYC (M), .NBITS (16), .MOUSE_EN (1'b1)
    ) i_gamepad_poll_host (
        .clk (clk), .rst_n (rst_n), .pad_data_i (pad_data),
        .latch_pull_o (latch_pull), .clk_pull_o (clk_pull),
        .buttons_o (buttons), .motion_o (motion), .valid_o (valid),
        .mouse_o (mouse), .nodev_o (nodev)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit run = 1'b0;
    int frames_done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // ---------------- pad / mouse device model ----------------
    bit          dev_present = 1'b0;
    logic [31:0] dev_pressed = '0;
    logic [31:0] dev_sh = '1;
    int          dev_idx = 0;
    logic        prev_cp = 1'b0;

    always @(negedge clk) begin
        if (!dev_present) begin
            pad_data = 1'b1;
        end else if (!latch_pull) begin
            dev_sh   = ~dev_pressed;
            dev_idx  = 0;
            pad_data = dev_sh[0];
        end else if (prev_cp && !clk_pull) begin
            dev_idx++;
            if (dev_idx < (dev_pressed[15] ? 32 : 16)) pad_data = dev_sh[dev_idx];
            else                                       pad_data = 1'b0;
        end
        prev_cp = clk_pull;
    end

    // ---------------- behavioural reference schedule ----------------
    int          k = 0;
    bit          fr_present = 1'b0;
    logic [31:0] fr_pressed = '0;
    logic [15:0] ex_btn = '0, ex_mot = '0;
    logic        ex_mouse = 1'b0, ex_nodev = 1'b0;

    function automatic bit in_low(input int o, input int base);
        int r;
        if (o < base || o >= base + 32 * H) return 1'b0;
        r = (o - base) % (2 * H);
        return r < H;
    endfunction

    always @(negedge clk) begin
        if (run) begin
            int  o;
            bit  mfr;
            bit  e_latch, e_clk, e_valid;
            k++;
            e_latch = 1'b1; e_clk = 1'b0; e_valid = 1'b0;
            if (k >= F) begin
                o = k % F;
                if (o == 0) begin
                    fr_present = dev_present;
                    fr_pressed = dev_pressed;
                end
                mfr     = fr_present && fr_pressed[15];
                e_latch = !(o < L);
                e_clk   = in_low(o, L + G) || (mfr && in_low(o, B2));
                e_valid = (o == (mfr ? T1 : T0));
            end
            chk("R1 R2 latch", latch_pull, e_latch);
            chk("R3 clock", clk_pull, e_clk);
            chk("R10 clock while latch", !latch_pull && clk_pull, 1'b0);
            chk("R5 valid", valid, e_valid);
            if (e_valid) begin
                ex_btn   = fr_present ? fr_pressed[15:0] : 16'h0;
                ex_mouse = fr_present && fr_pressed[15];
                ex_mot   = ex_mouse ? fr_pressed[31:16] : 16'h0;
                ex_nodev = (ex_btn == 16'h0);
                frames_done++;
            end
            chk("R4 buttons", buttons, ex_btn);
            chk("R6 motion", motion, ex_mot);
            chk("R7 mouse", mouse, ex_mouse);
            chk("R8 nodev", nodev, ex_nodev);
        end
    end

    // ---------------- stimulus ----------------
    task automatic next_frame(input bit present, input logic [31:0] pressed);
        @(negedge clk);
        dev_present = present;
        dev_pressed = pressed;
        wait (frames_done == frames_done + 0);
    endtask

    initial begin
        int target;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        // R9 reset state
        chk("R9 latch", latch_pull, 1'b1);
        chk("R9 clock", clk_pull, 1'b0);
        chk("R9 valid", valid, 1'b0);
        chk("R9 outputs", {buttons, motion}, 32'h0);
        chk("R9 flags", {mouse, nodev}, 2'b00);
        @(negedge clk);
        #1 rst_n = 1'b1;
        run = 1'b1;
        // frame 1: empty port (R8)
        target = 1;
        wait (frames_done == target);
        // frame 2: B + Select pressed (R4)
        next_frame(1'b1, 32'h0000_0005);  target++; wait (frames_done == target);
        // frame 3: every assigned button (R4)
        next_frame(1'b1, 32'h0000_0FFF);  target++; wait (frames_done == target);
        // frame 4: pad present, nothing pressed (R8)
        next_frame(1'b1, 32'h0000_0000);  target++; wait (frames_done == target);
        // frame 5: mouse with motion report (R6, R7)
        next_frame(1'b1, 32'h3C81_8300);  target++; wait (frames_done == target);
        // frame 6: gamepad after mouse, motion must clear (R7)
        next_frame(1'b1, 32'h0000_0A50);  target++; wait (frames_done == target);
        // frame 7: mouse with no movement (R6)
        next_frame(1'b1, 32'h0000_8000);  target++; wait (frames_done == target);
        // frame 8: port emptied again (R8)
        next_frame(1'b0, 32'h0000_0000);  target++; wait (frames_done == target);
        repeat (20) @(negedge clk);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d frames expected 8", frames_done);
        summary();
    end
endmodule